// File: doc/BRIEF.md
# Single-Wire Time-Slot Host Controller

This block is the host side of a single-wire serial memory bus. It drives the shared line only through an open-drain pull-down enable and reads the line back through a synchronised input. Each transaction starts with a single-cycle start request. The block then synchronises the slave with a run of long-low (write-zero) slots. Next it sends an eight-bit command that selects a read or a write. Last, it moves 256 data bits, least significant bit first.

On a write, the bits come from a 256-bit buffer that is loaded when the request is accepted. On a read, the line level in each data slot is shifted into the same buffer. The low times, the read sample point, the slot length and the recovery gap are cycle-count parameters. Their defaults are derived from the clock frequency in MHz. A transaction cannot be interrupted. While one is running, the block reports busy. It gives a one-cycle done pulse once the last data slot has ended.

Top module: `ow_slot_host`

## Requirements
- R1: After reset, and at all times outside a transaction, the line is released (`line_pull_o` = 0), `busy_o` and `done_o` are 0, and `rd_data_o` is 0 straight after reset.
- R2: A start request is accepted only when the block is idle. A request made during a transaction adds no slots, and it changes neither the direction nor the data of the running transaction.
- R3: Each transaction begins with exactly SYNC_SLOTS (264) write-zero slots.
- R4: The command follows the synchronisation slots as eight slots in time order: a write-one slot, two write-zero slots, then five write-one slots for a write or five write-zero slots for a read.
- R5: In a write-one slot and in a read slot, the line is pulled low for T_LOW_SHORT cycles. In a write-zero slot it is pulled low for T_LOW_LONG cycles, and T_LOW_LONG never exceeds T_SLOT.
- R6: Consecutive slots start exactly T_SLOT + T_REC cycles apart, and the line is released for the last T_REC cycles of every slot.
- R7: In a write, data slot k (counting from 0) is a write-one slot when bit k of the word captured at acceptance is 1, and a write-zero slot when it is 0.
- R8: In a read, the 256 data slots are all read slots. Bit k of `rd_data_o` takes the synchronised line level sampled T_SAMPLE cycles into data slot k.
- R9: `busy_o` is high for exactly 528 × (T_SLOT + T_REC) cycles after acceptance. Then `done_o` is high for exactly one cycle while `busy_o` is low.
- R10: After a write completes, `rd_data_o` equals the word that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle transaction request |
| write_i | input | 1 | 1 selects a write, 0 a read; sampled with start_i |
| wr_data_i | input | DATA_BITS | Word to write; captured on acceptance |
| rd_data_o | output | DATA_BITS | Buffer contents: read result, or retained write word |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse after the last data slot |
| line_pull_o | output | 1 | Open-drain enable; 1 pulls the line low |
| line_i | input | 1 | Line level as seen at the pin |

## Verification
The hardest case to create from the ports is a start request, together with a different direction and a different write word, that arrives deep inside a transaction. That request must leave no trace at all. To reach it, the bench raises such a request thousands of cycles into both a read and a write. A scoreboard checks every later slot against the expectation that was built when the transaction was launched. A behavioural slave also holds the line low through the sample point in read slots whose memory bit is 0. This exercises the receive path with sparse, dense and single-bit patterns.

// File: rtl/ow_host_pkg.sv
package ow_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYNC = 3'd1,
    ST_CMD  = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    SLOT_W0 = 2'd0,
    SLOT_W1 = 2'd1,
    SLOT_RD = 2'd2
  } slot_kind_e;

  // Command is eight slots; the first three are fixed (one, zero, zero).
  localparam int unsigned CMD_LEN = 8;
  localparam int unsigned CMD_HDR = 3;

endpackage

// File: rtl/ow_in_sync.sv
module ow_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_d;

      always_comb begin
        sh_d = STAGES'({sh_q, d_i});
      end

      // Idle line is high, so the chain resets to ones.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '1;
        end else begin
          sh_q <= sh_d;
        end
      end

      assign q_o = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer
  import ow_host_pkg::*;
#(
  parameter int unsigned LOW_SHORT = 1500,
  parameter int unsigned LOW_LONG  = 17500,
  parameter int unsigned SAMPLE_AT = 3250,
  parameter int unsigned SLOT_LEN  = 17500,
  parameter int unsigned REC_LEN   = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  slot_kind_e kind_i,
  output logic       pull_o,
  output logic       sample_o,
  output logic       slot_end_o
);

  localparam int unsigned PERIOD = SLOT_LEN + REC_LEN;
  localparam int unsigned CW     = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] low_len;
  logic          cnt_en;

  always_comb begin
    low_len    = (kind_i == SLOT_W0) ? CW'(LOW_LONG) : CW'(LOW_SHORT);
    slot_end_o = run_i && (cnt_q == CW'(PERIOD - 1));
    pull_o     = run_i && (cnt_q < low_len);
    sample_o   = run_i && (kind_i == SLOT_RD) && (cnt_q == CW'(SAMPLE_AT));
  end

  always_comb begin
    cnt_en = run_i || (cnt_q != '0);
    if (!run_i || slot_end_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R6: the recovery tail of every slot leaves the line released.
  a_r6_recovery_released: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (cnt_q >= CW'(SLOT_LEN))) |-> !pull_o);

  // R5: every slot opens with the line pulled low.
  a_r5_slot_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (cnt_q == '0)) |-> pull_o);

  // R8: the host has already released the line when it samples.
  a_r8_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> !pull_o);

endmodule

// File: rtl/ow_seq_ctrl.sv
module ow_seq_ctrl
  import ow_host_pkg::*;
#(
  parameter int unsigned SYNC_SLOTS = 264,
  parameter int unsigned DATA_BITS  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       write_i,
  input  logic       slot_end_i,
  input  logic       wbit_i,
  output logic       run_o,
  output slot_kind_e kind_o,
  output logic       load_o,
  output logic       shift_o,
  output logic       rotate_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int unsigned MAX_A = (SYNC_SLOTS > DATA_BITS) ? SYNC_SLOTS : DATA_BITS;
  localparam int unsigned MAXN  = (MAX_A > CMD_LEN) ? MAX_A : CMD_LEN;
  localparam int unsigned IW    = $clog2(MAXN);
  localparam logic [IW-1:0] SYNC_LAST = IW'(SYNC_SLOTS - 1);
  localparam logic [IW-1:0] CMD_LAST  = IW'(CMD_LEN - 1);
  localparam logic [IW-1:0] DATA_LAST = IW'(DATA_BITS - 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          wr_q, wr_d;
  logic          idx_en, wr_en, accept;
  logic          cmd_bit;

  always_comb begin
    accept = (state_q == ST_IDLE) && start_i;
    idx_en = accept || slot_end_i;
    wr_en  = accept;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wr_d    = wr_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SYNC;
          idx_d   = '0;
          wr_d    = write_i;
        end
      end
      ST_SYNC: begin
        if (slot_end_i) begin
          if (idx_q == SYNC_LAST) begin
            state_d = ST_CMD;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      ST_CMD: begin
        if (slot_end_i) begin
          if (idx_q == CMD_LAST) begin
            state_d = ST_DATA;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      ST_DATA: begin
        if (slot_end_i) begin
          if (idx_q == DATA_LAST) begin
            state_d = ST_DONE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Command bit order: marker one, two zero select bits, then five direction bits.
  always_comb begin
    if (idx_q == '0) begin
      cmd_bit = 1'b1;
    end else if (idx_q < IW'(CMD_HDR)) begin
      cmd_bit = 1'b0;
    end else begin
      cmd_bit = wr_q;
    end
  end

  always_comb begin
    case (state_q)
      ST_SYNC: kind_o = SLOT_W0;
      ST_CMD:  kind_o = cmd_bit ? SLOT_W1 : SLOT_W0;
      ST_DATA: kind_o = wr_q ? (wbit_i ? SLOT_W1 : SLOT_W0) : SLOT_RD;
      default: kind_o = SLOT_W0;
    endcase
    busy_o   = (state_q == ST_SYNC) || (state_q == ST_CMD) || (state_q == ST_DATA);
    done_o   = (state_q == ST_DONE);
    run_o    = busy_o;
    load_o   = accept;
    shift_o  = (state_q == ST_DATA) && slot_end_i;
    rotate_o = wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
    end else if (wr_en) begin
      wr_q <= wr_d;
    end
  end

  // R9: done lasts a single cycle.
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: done only follows the data phase and never overlaps busy.
  a_r9_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!busy_o && ($past(state_q) == ST_DATA)));

  // R3: every transaction opens in the sync phase at slot zero.
  a_r3_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ((state_q == ST_SYNC) && (idx_q == '0)));

  // R2: a request while busy does not change the captured direction.
  a_r2_direction_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(wr_q));

endmodule

// File: rtl/ow_shift_buf.sv
module ow_shift_buf #(
  parameter int unsigned W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         sample_i,
  input  logic         line_i,
  input  logic         shift_i,
  input  logic         rotate_i,
  output logic [W-1:0] data_o,
  output logic         lsb_o
);

  logic [W-1:0] buf_q, buf_d;
  logic         samp_q;
  logic         buf_en;
  logic         in_bit;

  always_comb begin
    buf_en = load_i || shift_i;
    // Writes recirculate the outgoing bit so the word survives the transfer.
    in_bit = rotate_i ? buf_q[0] : samp_q;
    if (load_i) begin
      buf_d = load_data_i;
    end else begin
      buf_d = {in_bit, buf_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
    end else if (sample_i) begin
      samp_q <= line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
    end
  end

  assign data_o = buf_q;
  assign lsb_o  = buf_q[0];

  // R10: without a load or a shift, the buffer keeps its contents.
  a_r10_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> $stable(buf_q));

endmodule

// File: rtl/ow_slot_host.sv
module ow_slot_host
  import ow_host_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned T_LOW_SHORT = 6 * CLK_MHZ,
  parameter int unsigned T_LOW_LONG  = 70 * CLK_MHZ,
  parameter int unsigned T_SAMPLE    = 13 * CLK_MHZ,
  parameter int unsigned T_SLOT      = 70 * CLK_MHZ,
  parameter int unsigned T_REC       = 5 * CLK_MHZ,
  parameter int unsigned SYNC_SLOTS  = 264,
  parameter int unsigned DATA_BITS   = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 write_i,
  input  logic [DATA_BITS-1:0] wr_data_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 line_pull_o,
  input  logic                 line_i
);

  logic       run, load, shift, rotate, lsb;
  logic       sample, slot_end, line_s;
  slot_kind_e kind;

  ow_in_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  ow_seq_ctrl #(
    .SYNC_SLOTS (SYNC_SLOTS),
    .DATA_BITS  (DATA_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .write_i    (write_i),
    .slot_end_i (slot_end),
    .wbit_i     (lsb),
    .run_o      (run),
    .kind_o     (kind),
    .load_o     (load),
    .shift_o    (shift),
    .rotate_o   (rotate),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  ow_slot_timer #(
    .LOW_SHORT (T_LOW_SHORT),
    .LOW_LONG  (T_LOW_LONG),
    .SAMPLE_AT (T_SAMPLE),
    .SLOT_LEN  (T_SLOT),
    .REC_LEN   (T_REC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .kind_i     (kind),
    .pull_o     (line_pull_o),
    .sample_o   (sample),
    .slot_end_o (slot_end)
  );

  ow_shift_buf #(
    .W (DATA_BITS)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .load_data_i (wr_data_i),
    .sample_i    (sample),
    .line_i      (line_s),
    .shift_i     (shift),
    .rotate_i    (rotate),
    .data_o      (rd_data_o),
    .lsb_o       (lsb)
  );

  // R1: the line is never pulled outside a transaction.
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !line_pull_o);

endmodule

// File: tb/ow_slot_host_bench.sv
`timescale 1ns/1ps
module ow_slot_host_bench;

  localparam int unsigned LS = 3, LL = 12, SA = 7, SL = 12, RC = 2;
  localparam int unsigned PER = SL + RC;
  localparam int unsigned NB = 256;
  localparam int unsigned TOTAL_SLOTS = 264 + 8 + NB;

  typedef struct {
    bit    short_lo;
    bit    slave0;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, write;
  logic [NB-1:0] wr_data;
  logic [NB-1:0] rd_data;
  logic          busy, done, pull;
  logic          slave_pull;
  wire           line = ~(pull | slave_pull);

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  exp_t cur;
  bit   have_cur, rise_valid, prev_pull;
  int   cyc, last_rise, low_cnt, slave_cnt;

  always #2 clk = ~clk;

  ow_slot_host #(
    .T_LOW_SHORT (LS), .T_LOW_LONG (LL), .T_SAMPLE (SA),
    .T_SLOT (SL), .T_REC (RC)
  ) u_ow_slot_host (
    .clk (clk), .rst_n (rst_n), .start_i (start), .write_i (write),
    .wr_data_i (wr_data), .rd_data_o (rd_data), .busy_o (busy),
    .done_o (done), .line_pull_o (pull), .line_i (line)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor and behavioural slave: pop one expectation per slot and compare.
  always @(negedge clk) begin
    cyc++;
    if (slave_cnt > 0) begin
      slave_cnt--;
      if (slave_cnt == 0) slave_pull = 1'b0;
    end
    if (pull && !prev_pull) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected slot", 1, 0);
        have_cur = 1'b0;
      end else begin
        cur = q.pop_front();
        have_cur = 1'b1;
        if (cur.slave0) begin
          slave_pull = 1'b1;
          slave_cnt  = 9;
        end
      end
      if (rise_valid) check((cyc - last_rise) == PER, "R6 slot period", cyc - last_rise, PER);
      last_rise  = cyc;
      rise_valid = 1'b1;
      low_cnt    = 0;
    end
    if (pull) low_cnt++;
    if (!pull && prev_pull && have_cur) begin
      check(low_cnt == (cur.short_lo ? LS : LL), {cur.req, " R5 low width"},
            low_cnt, cur.short_lo ? LS : LL);
      have_cur = 1'b0;
    end
    prev_pull = pull;
  end

  task automatic run_txn(input bit wr, input logic [NB-1:0] wd,
                         input logic [NB-1:0] mem, input bit poke);
    exp_t e;
    int   busy_cnt;
    int   guard;
    for (int i = 0; i < 264; i++) begin
      e.short_lo = 1'b0; e.slave0 = 1'b0; e.req = "R3";
      q.push_back(e);
    end
    for (int i = 0; i < 8; i++) begin
      e.short_lo = (i == 0) ? 1'b1 : (i < 3) ? 1'b0 : wr;
      e.slave0 = 1'b0; e.req = "R4";
      q.push_back(e);
    end
    for (int i = 0; i < NB; i++) begin
      if (wr) begin
        e.short_lo = wd[i]; e.slave0 = 1'b0; e.req = "R7";
      end else begin
        e.short_lo = 1'b1; e.slave0 = ~mem[i]; e.req = "R8";
      end
      q.push_back(e);
    end
    rise_valid = 1'b0;
    @(negedge clk);
    start = 1'b1; write = wr; wr_data = wd;
    @(negedge clk);
    start = 1'b0;
    busy_cnt = 0;
    guard = 0;
    while (!done && guard < 20000) begin
      if (busy) busy_cnt++;
      if (poke && busy_cnt == 3000) begin
        start = 1'b1; write = ~wr; wr_data = ~wd;   // R2: must be ignored
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    if (guard >= 20000) begin
      check(1'b0, "R9 watchdog: no done", guard, TOTAL_SLOTS * PER);
      finish_run();
    end
    check(busy_cnt == TOTAL_SLOTS * PER, "R9 busy length", busy_cnt, TOTAL_SLOTS * PER);
    check(!busy, "R9 busy low with done", busy, 0);
    @(negedge clk);
    check(!done, "R9 done single cycle", done, 0);
    check(q.size() == 0, "R3 all slots issued", q.size(), 0);
    if (wr) check_vec("R10 write word retained", rd_data, wd);
    else    check_vec("R8 read data", rd_data, mem);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!pull && !busy && !done, "R1 idle outputs", {pull, busy, done}, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; write = 1'b0; wr_data = '0;
    slave_pull = 1'b0; slave_cnt = 0; prev_pull = 1'b0; have_cur = 1'b0;
    rise_valid = 1'b0; cyc = 0; last_rise = 0; low_cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pull && !busy && !done, "R1 reset outputs", {pull, busy, done}, 0);
    check_vec("R1 reset buffer", rd_data, '0);

    run_txn(1'b1, {8{32'hA5C3_0F96}}, '0, 1'b0);
    run_txn(1'b0, '0, {4{64'h0123_4567_89AB_CDEF}}, 1'b1);
    run_txn(1'b1, {{128{1'b1}}, {128{1'b0}}}, '0, 1'b1);
    run_txn(1'b0, '0, {{(NB-1){1'b0}}, 1'b1}, 1'b0);

    finish_run();
  end

endmodule